// File: doc/BRIEF.md
# Saturating Wiper Position Controller

This block keeps the position of the wiper on a 100-tap digitally controlled resistor ladder and turns it into a one-hot tap-select vector. A host moves the wiper through three asynchronous wires: an active-low select, a direction level and an increment strobe. The block brings all three into the system clock domain and watches the strobe for its falling edge. On each such edge, while the block is selected, the position moves one tap toward the end that the direction level picks.

The position is a 7-bit value that stops at tap 0 and at tap 99 and never wraps. A synchronous load port lets a value recalled from storage outside the block overwrite the position. A load above the top tap is clamped to it. If a load and a strobe step fall in the same cycle, the load wins. The system clock must run fast enough that each strobe low phase and high phase (at least 1 us) spans several clock cycles.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: After reset the position output is 0 and only tap-select bit 0 is high.
- R2: A strobe high-to-low transition while select is low and direction is high raises the position by one.
- R3: A strobe high-to-low transition while select is low and direction is low lowers the position by one.
- R4: An up step at position 99 leaves the position at 99.
- R5: A down step at position 0 leaves the position at 0.
- R6: Strobe transitions while select is high leave the position unchanged.
- R7: A strobe low-to-high transition never changes the position.
- R8: The direction level may change between strobe pulses within one selection, and each step follows the level present at its own falling edge.
- R9: Exactly one tap-select bit is high, and bit k is the high one when the position is k (bit 0 is tap 0, bit 99 is tap 99).
- R10: A load pulse sets the position to the load value on the next clock edge, and a load value above 99 gives position 99.
- R11: A load in the same cycle as a detected strobe step takes priority, and the step is lost.
- R12: The position never exceeds 99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| sel_n_i | input | 1 | Asynchronous select, low means selected |
| dir_i | input | 1 | Asynchronous direction, high moves up and low moves down |
| strobe_i | input | 1 | Asynchronous increment strobe, acts on its falling edge |
| load_en_i | input | 1 | Synchronous one-cycle load request |
| load_val_i | input | 7 | Position to load, clamped to 99 |
| pos_o | output | 7 | Current wiper position, 0 to 99 |
| tap_o | output | 100 | One-hot tap select |

## Verification
The bench drives the wiper into both ends and keeps stepping past them. A counter that wraps would show 0 after 99, or 99 after 0, and one that ignored the top bound would reach 100. It also pulses the strobe while the block is deselected and checks after strobe rising edges, which catches a design that steps on the wrong edge or ignores the select input. Loads of 120 and 97 expose a missing clamp. A load timed to land in the same cycle as a detected falling edge shows whether the step wrongly overrides the load.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int DEF_TAPS = 100;

  typedef struct packed {
    logic sel_n;
    logic dir;
    logic strobe;
  } wpc_ctl_t;

  localparam wpc_ctl_t CTL_IDLE = '{sel_n: 1'b1, dir: 1'b0, strobe: 1'b1};
endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
  parameter int                WIDTH   = 3,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= RST_VAL;
        end else begin
          if (s == 0) stage_q[s] <= d_i;
          else        stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wpc_counter.sv
module wpc_counter #(
  parameter int TAPS  = 100,
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n_s,
  input  logic             dir_s,
  input  logic             strobe_s,
  input  logic             load_en,
  input  logic [POS_W-1:0] load_val,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] MAX_POS = POS_W'(TAPS - 1);

  logic             strobe_d;
  logic             fall;
  logic             step;
  logic             upd;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;

  always_comb begin
    fall = strobe_d & ~strobe_s;
    step = fall & ~sel_n_s;
    upd  = load_en | step;
    pos_d = pos_q;
    if (load_en) begin
      pos_d = (load_val > MAX_POS) ? MAX_POS : load_val;
    end else if (step) begin
      if (dir_s) pos_d = (pos_q == MAX_POS) ? pos_q : pos_q + 1'b1;
      else       pos_d = (pos_q == '0)      ? pos_q : pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d <= 1'b1;
    end else begin
      strobe_d <= strobe_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (upd) begin
      pos_q <= pos_d;
    end
  end

  assign pos = pos_q;

  p_in_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= MAX_POS);
  p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dir_s && !load_en && pos_q < MAX_POS) |=> pos_q == $past(pos_q) + 1'b1);
  p_dn_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !dir_s && !load_en && pos_q != '0) |=> pos_q == $past(pos_q) - 1'b1);
  p_top_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dir_s && !load_en && pos_q == MAX_POS) |=> pos_q == MAX_POS);
  p_bottom_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !dir_s && !load_en && pos_q == '0) |=> pos_q == '0);
  p_deselect_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n_s && !load_en) |=> $stable(pos_q));
  p_rise_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_s && !load_en) |=> $stable(pos_q));
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_val <= MAX_POS) |=> pos_q == $past(load_val));
  p_load_clamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_val > MAX_POS) |=> pos_q == MAX_POS);
endmodule

// File: rtl/wpc_decode.sv
module wpc_decode #(
  parameter int TAPS  = 100,
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap
);
  genvar i;
  generate
    for (i = 0; i < TAPS; i++) begin : g_tap
      assign tap[i] = (pos == POS_W'(i));
    end
  endgenerate

  p_one_hot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap) == 1);
  p_tap_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tap[pos] == 1'b1);
endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl #(
  parameter int TAPS  = wpc_pkg::DEF_TAPS,
  parameter int POS_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n_i,
  input  logic             dir_i,
  input  logic             strobe_i,
  input  logic             load_en_i,
  input  logic [POS_W-1:0] load_val_i,
  output logic [POS_W-1:0] pos_o,
  output logic [TAPS-1:0]  tap_o
);
  import wpc_pkg::*;

  wpc_ctl_t ctl_raw;
  wpc_ctl_t ctl_s;

  assign ctl_raw = '{sel_n: sel_n_i, dir: dir_i, strobe: strobe_i};

  wpc_sync #(
    .WIDTH  ($bits(wpc_ctl_t)),
    .STAGES (2),
    .RST_VAL(CTL_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (ctl_raw),
    .q_o  (ctl_s)
  );

  wpc_counter #(
    .TAPS (TAPS),
    .POS_W(POS_W)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n_s (ctl_s.sel_n),
    .dir_s   (ctl_s.dir),
    .strobe_s(ctl_s.strobe),
    .load_en (load_en_i),
    .load_val(load_val_i),
    .pos     (pos_o)
  );

  wpc_decode #(
    .TAPS (TAPS),
    .POS_W(POS_W)
  ) u_decode (
    .clk  (clk),
    .rst_n(rst_n),
    .pos  (pos_o),
    .tap  (tap_o)
  );
endmodule

// File: tb/test_wiper_pos_ctrl.sv
module test_wiper_pos_ctrl;
  localparam int TAPS  = 100;
  localparam int POS_W = 7;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             sel_n_i;
  logic             dir_i;
  logic             strobe_i;
  logic             load_en_i;
  logic [POS_W-1:0] load_val_i;
  logic [POS_W-1:0] pos_o;
  logic [TAPS-1:0]  tap_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int model  = 0;

  typedef struct {
    int    exp;
    string req;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  wiper_pos_ctrl #(.TAPS(TAPS), .POS_W(POS_W)) i_wiper_pos_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n_i), .dir_i(dir_i),
    .strobe_i(strobe_i), .load_en_i(load_en_i), .load_val_i(load_val_i),
    .pos_o(pos_o), .tap_o(tap_o)
  );

  // Monitor: pops expected items and compares at a falling clock edge
  initial begin
    forever begin
      wait (q.size() > 0);
      @(negedge clk);
      begin
        item_t it;
        logic [TAPS-1:0] exp_tap;
        it = q.pop_front();
        exp_tap = '0;
        exp_tap[it.exp] = 1'b1;
        checks++;
        if (int'(pos_o) != it.exp) begin
          errors++;
          $display("FAIL %s: pos actual %0d expected %0d", it.req, pos_o, it.exp);
        end
        checks++;
        if (tap_o !== exp_tap) begin
          errors++;
          $display("FAIL R9 (%s): tap actual %h expected %h", it.req, tap_o, exp_tap);
        end
      end
    end
  end

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_pos(input string req);
    item_t it;
    settle();
    it.exp = model;
    it.req = req;
    q.push_back(it);
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe_fall();
    @(negedge clk);
    strobe_i = 1'b0;
    if (!sel_n_i) begin
      if (dir_i) model = (model == TAPS - 1) ? model : model + 1;
      else       model = (model == 0) ? 0 : model - 1;
    end
    settle();
  endtask

  task automatic strobe_rise();
    @(negedge clk);
    strobe_i = 1'b1;
    settle();
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      strobe_fall();
      strobe_rise();
    end
  endtask

  task automatic load(input int v);
    @(negedge clk);
    load_en_i  = 1'b1;
    load_val_i = POS_W'(v);
    @(negedge clk);
    load_en_i  = 1'b0;
    model = (v > TAPS - 1) ? TAPS - 1 : v;
  endtask

  initial begin
    rst_n = 1'b0; sel_n_i = 1'b1; dir_i = 1'b0; strobe_i = 1'b1;
    load_en_i = 1'b0; load_val_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    expect_pos("R1 reset");

    sel_n_i = 1'b0; dir_i = 1'b1; settle();
    pulse(3);
    expect_pos("R2 up steps");

    dir_i = 1'b0; settle();
    pulse(1);
    expect_pos("R3 down step");

    dir_i = 1'b1; settle(); pulse(2);
    dir_i = 1'b0; settle(); pulse(1);
    dir_i = 1'b1; settle(); pulse(1);
    expect_pos("R8 direction changes in one selection");

    strobe_fall();
    expect_pos("R2 after falling edge");
    strobe_rise();
    expect_pos("R7 rising edge holds");

    sel_n_i = 1'b1; settle();
    pulse(4);
    expect_pos("R6 deselected strobes ignored");
    sel_n_i = 1'b0; settle();

    load(97);
    expect_pos("R10 load 97");
    dir_i = 1'b1; settle();
    pulse(5);
    expect_pos("R4 saturate at 99");

    load(120);
    expect_pos("R10 load clamp 120");

    load(1);
    dir_i = 1'b0; settle();
    pulse(3);
    expect_pos("R5 saturate at 0");

    // R11: load lands in the cycle where the strobe fall is detected
    load(10);
    dir_i = 1'b1; settle();
    @(negedge clk); strobe_i = 1'b0;
    @(negedge clk);
    @(negedge clk); load_en_i = 1'b1; load_val_i = 7'd40;
    @(negedge clk); load_en_i = 1'b0;
    model = 40;
    expect_pos("R11 load beats step");
    strobe_rise();
    expect_pos("R11 after release");

    repeat (10) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule